// File: doc/BRIEF.md
# Interrupt destination bitmask generator

This block works out which of `N_CTRL` local interrupt controllers accept an inter-processor message. The sender supplies a 32-bit destination word, an addressing mode (physical or logical), a 2-bit shorthand and its own controller index. The block also takes the state of every controller: its initial ID, whether it runs in extended (32-bit) mode, whether its legacy logical model is flat or cluster, and its 8-bit legacy logical ID.

The accept mask is built combinationally from these inputs and registered once, so it appears one cycle after a valid request. For lowest-priority delivery the block also reports the lowest-numbered accepting controller, together with a flag that is low when no controller accepts. The payload, the transport of the message and any priority arbitration between processors are handled elsewhere.

Top module: `ipi_dest_mask`

## Requirements
- R1: With shorthand 0 the mask comes from decoding the destination word under the selected mode (logical_i = 0 physical, 1 logical); the shorthand encoding is 0 destination, 1 self, 2 all, 3 all but self.
- R2: Shorthand 1 sets only the bit of the controller named by sender_i.
- R3: Shorthand 2 sets every bit of the mask.
- R4: Shorthand 3 sets every bit except the bit named by sender_i.
- R5: In physical mode a destination of 0xFFFFFFFF sets every bit.
- R6: In physical mode an extended-mode controller accepts when its full 32-bit ID equals the destination; a legacy controller accepts when bits 7:0 of its ID equal destination bits 7:0.
- R7: In physical mode a destination equal to exactly 0x000000FF also selects every legacy controller.
- R8: In logical mode an extended-mode controller uses a logical ID derived from its initial ID (bits 31:16 = ID bits 19:4, bits 15:0 = 1 shifted left by ID bits 3:0) and accepts when destination bits 31:16 equal the derived bits 31:16 and destination bits 15:0 share a set bit with derived bits 15:0; a destination of 0xFFFFFFFF selects every extended-mode controller.
- R9: In logical mode a legacy controller in the flat model (cluster flag 0) accepts when destination bits 7:0 share a set bit with its logical ID.
- R10: In logical mode a legacy controller in the cluster model (cluster flag 1) accepts when destination bits 7:4 are 0xF or equal its logical ID bits 7:4, and destination bits 3:0 share a set bit with its logical ID bits 3:0.
- R11: mask_valid_o is high exactly one cycle after req_valid_i and carries the mask of that request; with no request the mask reads zero; after reset all outputs are zero.
- R12: pick_idx_o is the lowest set bit of mask_o and pick_valid_o is high only when mask_valid_o is high and the mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| dest_i | input | 32 | Destination word |
| logical_i | input | 1 | 0 physical, 1 logical addressing |
| shorthand_i | input | 2 | 0 destination, 1 self, 2 all, 3 all but self |
| sender_i | input | IDX_W | Index of the sending controller |
| ctrl_id_i | input | 32*N_CTRL | Initial ID of each controller |
| ctrl_x2_i | input | N_CTRL | Controller is in extended mode |
| ctrl_cluster_i | input | N_CTRL | Legacy logical model is cluster (else flat) |
| ctrl_ldest_i | input | 8*N_CTRL | Legacy logical ID of each controller |
| mask_valid_o | output | 1 | Registered mask is valid |
| mask_o | output | N_CTRL | Accept mask |
| pick_valid_o | output | 1 | Lowest-index pick is valid |
| pick_idx_o | output | IDX_W | Lowest accepting controller index |

## Verification
The assertions assume that sender_i always names an existing controller, that is, it is below N_CTRL whenever a request is valid. Under that assumption the self and all-but-self shorthands give exactly one bit set, or exactly one bit clear. The stimulus reduces every sender index modulo the controller count, and it holds the per-controller configuration fixed after reset, so a mask depends only on the request. Random requests are mixed with directed ones: broadcasts, a destination that no controller accepts, and senders at both ends of the index range.

// File: rtl/ipi_dest_pkg.sv
package ipi_dest_pkg;
  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [31:0] DEST_ALL32 = 32'hFFFF_FFFF;
  localparam logic [31:0] DEST_ALL8  = 32'h0000_00FF;

  // logical ID an extended-mode controller takes from its initial ID
  function automatic logic [31:0] ext_logical_id(logic [31:0] init_id);
    logic [15:0] bit_sel;
    bit_sel = 16'h0001 << init_id[3:0];
    return {init_id[19:4], bit_sel};
  endfunction
endpackage

// File: rtl/dest_match_unit.sv
module dest_match_unit
  import ipi_dest_pkg::*;
(
  input  logic [31:0] dest_i,
  input  logic        logical_i,
  input  logic [31:0] id_i,
  input  logic        x2_i,
  input  logic        cluster_i,
  input  logic [7:0]  ldest_i,
  output logic        hit_o
);
  logic [31:0] ext_lid;
  logic        all32, all8;
  logic        phys_hit, ext_log_hit, flat_hit, clus_hit;

  assign ext_lid = ext_logical_id(id_i);
  assign all32   = (dest_i == DEST_ALL32);
  assign all8    = (dest_i == DEST_ALL8);

  always_comb begin
    if (x2_i) phys_hit = all32 || (id_i == dest_i);
    else      phys_hit = all32 || all8 || (id_i[7:0] == dest_i[7:0]);
  end

  assign ext_log_hit = all32 ||
                       ((dest_i[31:16] == ext_lid[31:16]) && |(dest_i[15:0] & ext_lid[15:0]));
  assign flat_hit    = |(dest_i[7:0] & ldest_i);
  assign clus_hit    = ((dest_i[7:4] == 4'hF) || (dest_i[7:4] == ldest_i[7:4])) &&
                       |(dest_i[3:0] & ldest_i[3:0]);

  always_comb begin
    if (!logical_i)     hit_o = phys_hit;
    else if (x2_i)      hit_o = ext_log_hit;
    else if (cluster_i) hit_o = clus_hit;
    else                hit_o = flat_hit;
  end
endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     mask_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             found_o
);
  always_comb begin
    idx_o   = '0;
    found_o = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (mask_i[k]) begin
        idx_o   = IDX_W'(k);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ipi_dest_mask.sv
module ipi_dest_mask
  import ipi_dest_pkg::*;
#(
  parameter int N_CTRL = 32,
  localparam int IDX_W = (N_CTRL > 1) ? $clog2(N_CTRL) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [31:0]           dest_i,
  input  logic                  logical_i,
  input  logic [1:0]            shorthand_i,
  input  logic [IDX_W-1:0]      sender_i,
  input  logic [N_CTRL*32-1:0]  ctrl_id_i,
  input  logic [N_CTRL-1:0]     ctrl_x2_i,
  input  logic [N_CTRL-1:0]     ctrl_cluster_i,
  input  logic [N_CTRL*8-1:0]   ctrl_ldest_i,
  output logic                  mask_valid_o,
  output logic [N_CTRL-1:0]     mask_o,
  output logic                  pick_valid_o,
  output logic [IDX_W-1:0]      pick_idx_o
);
  logic [N_CTRL-1:0] dest_hits, sender_oh, mask_d, mask_q;
  logic              valid_q, found;

  for (genvar g = 0; g < N_CTRL; g++) begin : g_match
    dest_match_unit u_match (
      .dest_i    (dest_i),
      .logical_i (logical_i),
      .id_i      (ctrl_id_i[g*32 +: 32]),
      .x2_i      (ctrl_x2_i[g]),
      .cluster_i (ctrl_cluster_i[g]),
      .ldest_i   (ctrl_ldest_i[g*8 +: 8]),
      .hit_o     (dest_hits[g])
    );
  end

  assign sender_oh = N_CTRL'(1) << sender_i;

  always_comb begin
    unique case (shorthand_e'(shorthand_i))
      SH_SELF:   mask_d = sender_oh;
      SH_ALL:    mask_d = '1;
      SH_OTHERS: mask_d = ~sender_oh;
      default:   mask_d = dest_hits;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      valid_q <= req_valid_i;
      mask_q  <= req_valid_i ? mask_d : '0;
    end
  end

  lowest_pick #(.N(N_CTRL), .IDX_W(IDX_W)) u_pick (
    .mask_i  (mask_q),
    .idx_o   (pick_idx_o),
    .found_o (found)
  );

  assign mask_valid_o = valid_q;
  assign mask_o       = mask_q;
  assign pick_valid_o = valid_q & found;
endmodule

// File: rtl/ipi_dest_mask_chk.sv
module ipi_dest_mask_chk #(
  parameter int N_CTRL = 32,
  localparam int IDX_W = (N_CTRL > 1) ? $clog2(N_CTRL) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [31:0]       dest_i,
  input logic              logical_i,
  input logic [1:0]        shorthand_i,
  input logic [IDX_W-1:0]  sender_i,
  input logic              mask_valid_o,
  input logic [N_CTRL-1:0] mask_o,
  input logic              pick_valid_o,
  input logic [IDX_W-1:0]  pick_idx_o
);
  assert_valid_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> mask_valid_o);
  assert_idle_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !mask_valid_o);
  assert_self_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && shorthand_i == 2'd1) |=> ($onehot0(mask_o) && mask_o[$past(sender_i)]));
  assert_all_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && shorthand_i == 2'd2) |=> (&mask_o));
  assert_all_but_self_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && shorthand_i == 2'd3) |=>
      ($countones(mask_o) == N_CTRL - 1 && !mask_o[$past(sender_i)]));
  assert_phys_bcast_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && shorthand_i == 2'd0 && !logical_i && dest_i == 32'hFFFF_FFFF) |=> (&mask_o));
  assert_pick_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_valid_o == (mask_valid_o && (|mask_o)));
  assert_pick_lowest_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_valid_o |-> (mask_o[pick_idx_o] &&
                      ((mask_o & ~({N_CTRL{1'b1}} << pick_idx_o)) == '0)));
endmodule

bind ipi_dest_mask ipi_dest_mask_chk #(.N_CTRL(N_CTRL)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .dest_i       (dest_i),
  .logical_i    (logical_i),
  .shorthand_i  (shorthand_i),
  .sender_i     (sender_i),
  .mask_valid_o (mask_valid_o),
  .mask_o       (mask_o),
  .pick_valid_o (pick_valid_o),
  .pick_idx_o   (pick_idx_o)
);

// File: tb/ipi_dest_mask_test.sv
module ipi_dest_mask_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int IW = 5;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [31:0]       dest_i = '0;
  logic              logical_i = 1'b0;
  logic [1:0]        shorthand_i = '0;
  logic [IW-1:0]     sender_i = '0;
  logic [N*32-1:0]   ctrl_id_i;
  logic [N-1:0]      ctrl_x2_i, ctrl_cluster_i;
  logic [N*8-1:0]    ctrl_ldest_i;
  logic              mask_valid_o, pick_valid_o;
  logic [N-1:0]      mask_o;
  logic [IW-1:0]     pick_idx_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int unsigned cid [N];
  bit          cx2 [N];
  bit          ccl [N];
  int unsigned cld [N];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ipi_dest_mask #(.N_CTRL(N)) uut (.*);

  function automatic logic [N-1:0] ref_mask(logic [31:0] d, bit lg, int sh, int snd);
    logic [N-1:0] m = '0;
    if (sh == 1) begin m[snd] = 1'b1; return m; end
    if (sh == 2) return '1;
    if (sh == 3) begin m = '1; m[snd] = 1'b0; return m; end
    for (int i = 0; i < N; i++) begin
      bit hit = 0;
      if (!lg) begin
        if (d == 32'hFFFFFFFF) hit = 1;
        else if (cx2[i]) hit = (cid[i] == d);
        else hit = (d == 32'hFF) || ((cid[i] % 256) == (d % 256));
      end else if (cx2[i]) begin
        int unsigned clus = (cid[i] / 16) % 65536;
        int unsigned bitv = 1 << (cid[i] % 16);
        hit = (d == 32'hFFFFFFFF) || ((d / 65536) == clus && ((d % 65536) & bitv) != 0);
      end else if (ccl[i]) begin
        int unsigned dh = (d % 256) / 16;
        hit = (dh == 15 || dh == cld[i] / 16) && (((d % 16) & (cld[i] % 16)) != 0);
      end else begin
        hit = ((d % 256) & cld[i]) != 0;
      end
      m[i] = hit;
    end
    return m;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(string tag, logic [31:0] d, bit lg, int sh, int snd);
    logic [N-1:0] exp;
    int lo;
    req_valid_i = 1'b1; dest_i = d; logical_i = lg;
    shorthand_i = 2'(sh); sender_i = IW'(snd);
    exp = ref_mask(d, lg, sh, snd);
    lo = -1;
    for (int i = N - 1; i >= 0; i--) if (exp[i]) lo = i;
    @(posedge clk_i); @(negedge clk_i);
    chk("R11 valid", 64'(mask_valid_o), 64'd1);
    chk(tag, 64'(mask_o), 64'(exp));
    chk("R12 pick_valid", 64'(pick_valid_o), 64'(lo >= 0));
    if (lo >= 0) chk("R12 pick_idx", 64'(pick_idx_o), 64'(lo));
    req_valid_i = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk_i); @(negedge clk_i);
    chk("R11 idle valid", 64'(mask_valid_o), 64'd0);
    chk("R11 idle mask", 64'(mask_o), 64'd0);
    chk("R12 idle pick", 64'(pick_valid_o), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      cid[i] = i * 17;
      cx2[i] = (i % 3 == 0);
      ccl[i] = (i % 2 == 1);
      cld[i] = (i * 37 + 5) % 256;
      ctrl_id_i[i*32 +: 32] = cid[i];
      ctrl_x2_i[i] = cx2[i];
      ctrl_cluster_i[i] = ccl[i];
      ctrl_ldest_i[i*8 +: 8] = 8'(cld[i]);
    end
    repeat (3) @(negedge clk_i);
    chk("R11 reset valid", 64'(mask_valid_o), 64'd0);
    chk("R11 reset mask", 64'(mask_o), 64'd0);
    chk("R12 reset pick", 64'(pick_valid_o), 64'd0);
    rst_ni = 1'b1;
    idle();

    send("R6 x2 full id", cid[3], 0, 0, 0);
    send("R6 legacy low byte", 32'hAB00_0000 | (cid[1] % 256), 0, 0, 0);
    send("R7 legacy bcast", 32'h0000_00FF, 0, 0, 0);
    send("R7 not bcast", 32'h0000_01FF, 0, 0, 0);
    send("R5 phys all", 32'hFFFF_FFFF, 0, 0, 7);
    send("R12 empty mask", 32'h1234_5600, 0, 0, 0);
    send("R8 x2 logical", {16'd6, 16'h0040}, 1, 0, 0);
    send("R8 logical all32", 32'hFFFF_FFFF, 1, 0, 0);
    send("R9 flat", 32'h0000_0003, 1, 0, 0);
    send("R10 cluster bcast", 32'h0000_00F5, 1, 0, 0);
    send("R10 cluster addr", 32'h0000_002A, 1, 0, 0);
    send("R2 self 0", 32'h0, 0, 1, 0);
    send("R2 self top", 32'h0, 0, 1, N - 1);
    send("R3 all", 32'h0, 1, 2, 9);
    send("R4 others 0", 32'h0, 0, 3, 0);
    send("R4 others top", 32'h0, 0, 3, N - 1);
    idle();

    for (int t = 0; t < 400; t++) begin
      int sh = ($urandom % 4 == 0) ? int'($urandom % 4) : 0;
      int snd = int'($urandom % N);
      bit lg = bit'($urandom % 2);
      logic [31:0] d;
      case ($urandom % 5)
        0: d = $urandom;
        1: d = cid[$urandom % N];
        2: d = {16'($urandom % 40), 16'(1 << ($urandom % 16))};
        3: d = $urandom % 256;
        default: d = ($urandom % 3 == 0) ? 32'hFFFF_FFFF : 32'h0000_00FF;
      endcase
      case (sh)
        1: send("R2 rand", d, lg, sh, snd);
        2: send("R3 rand", d, lg, sh, snd);
        3: send("R4 rand", d, lg, sh, snd);
        default: send("R1 rand", d, lg, sh, snd);
      endcase
      if ($urandom % 4 == 0) idle();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule